// File: doc/BRIEF.md
# Speculative Store Buffer with All-or-Nothing Commit

This block holds the stores a core issues inside a speculative region and keeps them away from memory until the region is confirmed. Each slot records a word address, the data and a byte-enable mask. A later store to an address that is already held is folded into the existing slot. It does not take a new slot. Loads can look up the buffer and receive the bytes gathered so far.

Every time a store opens a new slot, the block asks the coherence side for exclusive ownership of that address. The request uses a valid/ready handshake, and grants come back tagged by address. The request is therefore made well before the region ends.

When the core asks to commit, the block waits until every held address has been granted. It then raises a snoop-block signal and writes out all slots on a valid/ready write port. Snoops stay blocked for the whole drain, so no other agent can see part of the group. An abort before the drain begins empties the buffer in one cycle and tells the coherence side to cancel its outstanding requests. A store that finds the buffer full is rejected, and an overflow pulse is raised so the core can treat the region as misspeculated.

Top module: `spec_wbuf`

## Requirements
- R1: An accepted store never appears on the write port (wr_valid_o stays 0) until a commit has been requested and its drain has begun.
- R2: A store whose address matches a held slot replaces only the bytes whose enables are set, ORs its enables into the slot, and takes no new slot. No address is ever held twice. A new slot stores zero in the bytes its store did not enable.
- R3: Each newly opened slot raises exactly one ownership request (own_req_valid_o, own_req_addr_o), taken when own_req_ready_i is high. Requests go out in the order the slots were first stored, and merges raise none.
- R4: After commit_i, the write port stays idle until every held slot has received a grant on own_gnt_valid_i/own_gnt_addr_i. A grant is matched by address and counts only for a slot whose request was already taken.
- R5: The drain writes slots in first-store order, one per cycle in which wr_ready_i is high. snoop_block_o is high from the first drain cycle through the cycle where commit_done_o pulses with the buffer empty. abort_i has no effect during the drain.
- R6: abort_i outside the drain empties the buffer in one cycle and returns the block to idle. In the same cycle, own_cancel_o is high if any taken request is still ungranted. Grants that arrive afterwards change nothing.
- R7: A store to a new address while every slot is full is dropped, and ovf_o is high for exactly the next cycle.
- R8: ld_hit_o, ld_data_o and ld_be_o show, in the same cycle, the held slot whose address equals ld_addr_i. ld_hit_o is 0 when no slot matches.
- R9: After reset the buffer is empty and every output is 0.
- R10: Stores presented after commit_i and before commit_done_o are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid_i | input | 1 | Speculative store present |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| st_be_i | input | DATA_W/8 | Store byte enables |
| ld_addr_i | input | ADDR_W | Load lookup address |
| ld_hit_o | output | 1 | Load address is held |
| ld_data_o | output | DATA_W | Held data for the load |
| ld_be_o | output | DATA_W/8 | Held byte enables for the load |
| commit_i | input | 1 | Request to commit the region |
| abort_i | input | 1 | Request to discard the region |
| commit_done_o | output | 1 | Drain finished |
| own_req_valid_o | output | 1 | Ownership request present |
| own_req_ready_i | input | 1 | Ownership request taken |
| own_req_addr_o | output | ADDR_W | Address needing ownership |
| own_gnt_valid_i | input | 1 | Ownership grant |
| own_gnt_addr_i | input | ADDR_W | Address granted |
| own_cancel_o | output | 1 | Cancel outstanding requests |
| wr_valid_o | output | 1 | Drain write present |
| wr_ready_i | input | 1 | Drain write taken |
| wr_addr_o | output | ADDR_W | Drain write address |
| wr_data_o | output | DATA_W | Drain write data |
| wr_be_o | output | DATA_W/8 | Drain write byte enables |
| snoop_block_o | output | 1 | Snoops held off during drain |
| ovf_o | output | 1 | Store rejected, buffer full |

## Verification
The bench builds the block with DEPTH=4, DATA_W=32 and ADDR_W=16. With four slots, a full buffer and the overflow reject are reached after a handful of stores. A short address also keeps the traces of the request and grant order easy to read. The 32-bit data keeps four byte lanes, so partial merges into single bytes are exercised alongside whole-word stores.

// File: rtl/swb_pkg.sv
package swb_pkg;
   typedef enum logic [1:0] {
      SWB_IDLE  = 2'd0,
      SWB_WAIT  = 2'd1,
      SWB_DRAIN = 2'd2
   } swb_state_e;
endpackage

// File: rtl/swb_match.sv
module swb_match #(
   parameter int N  = 8,
   parameter int AW = 30
) (
   input  logic [AW-1:0] tag_i [N],
   input  logic [N-1:0]  vld_i,
   input  logic [AW-1:0] key_i,
   output logic [N-1:0]  hit_o
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_o[g] = vld_i[g] && (tag_i[g] == key_i);
   end
endmodule

// File: rtl/swb_first.sv
module swb_first #(
   parameter int N = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/spec_wbuf.sv
module spec_wbuf
   import swb_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 30,
   localparam int BE_W  = DATA_W / 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic [DATA_W-1:0] st_data_i,
   input  logic [BE_W-1:0]   st_be_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   output logic              ld_hit_o,
   output logic [DATA_W-1:0] ld_data_o,
   output logic [BE_W-1:0]   ld_be_o,
   input  logic              commit_i,
   input  logic              abort_i,
   output logic              commit_done_o,
   output logic              own_req_valid_o,
   input  logic              own_req_ready_i,
   output logic [ADDR_W-1:0] own_req_addr_o,
   input  logic              own_gnt_valid_i,
   input  logic [ADDR_W-1:0] own_gnt_addr_i,
   output logic              own_cancel_o,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [BE_W-1:0]   wr_be_o,
   output logic              snoop_block_o,
   output logic              ovf_o
);
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("spec_wbuf: DATA_W must be a whole number of bytes");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("spec_wbuf: DEPTH must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("spec_wbuf: ADDR_W must be positive");
   end

   swb_state_e        state_q, state_d;
   logic [DEPTH-1:0]  vld_q, vld_d, sent_q, sent_d, owned_q, owned_d;
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [BE_W-1:0]   be_q   [DEPTH];
   logic              ovf_q;

   logic [DEPTH-1:0]  st_hit, ld_hit, gnt_hit, gnt_take;
   logic              free_found, req_found, drn_found;
   logic [IDX_W-1:0]  free_idx, req_idx, drn_idx;
   logic              store_try, store_alloc, store_merge, kill, all_owned;

   swb_match #(.N(DEPTH), .AW(ADDR_W)) u_st_match (
      .tag_i(addr_q), .vld_i(vld_q), .key_i(st_addr_i), .hit_o(st_hit));
   swb_match #(.N(DEPTH), .AW(ADDR_W)) u_ld_match (
      .tag_i(addr_q), .vld_i(vld_q), .key_i(ld_addr_i), .hit_o(ld_hit));
   swb_match #(.N(DEPTH), .AW(ADDR_W)) u_gnt_match (
      .tag_i(addr_q), .vld_i(vld_q), .key_i(own_gnt_addr_i), .hit_o(gnt_hit));

   swb_first #(.N(DEPTH)) u_free_pick (
      .req_i(~vld_q), .found_o(free_found), .idx_o(free_idx));
   swb_first #(.N(DEPTH)) u_req_pick (
      .req_i(vld_q & ~sent_q), .found_o(req_found), .idx_o(req_idx));
   swb_first #(.N(DEPTH)) u_drn_pick (
      .req_i(vld_q), .found_o(drn_found), .idx_o(drn_idx));

   assign kill        = abort_i && (state_q != SWB_DRAIN);
   assign store_try   = st_valid_i && (state_q == SWB_IDLE) && !abort_i;
   assign store_merge = store_try && (|st_hit);
   assign store_alloc = store_try && !(|st_hit) && free_found;
   assign all_owned   = &(~vld_q | owned_q);
   assign gnt_take    = gnt_hit & sent_q & ~owned_q & {DEPTH{own_gnt_valid_i}};

   // Ownership request side
   assign own_req_valid_o = (state_q != SWB_DRAIN) && req_found && !abort_i;
   assign own_req_addr_o  = addr_q[req_idx];
   assign own_cancel_o    = kill && (|(vld_q & sent_q & ~owned_q));

   // Drain side
   assign snoop_block_o = (state_q == SWB_DRAIN);
   assign wr_valid_o    = snoop_block_o && drn_found;
   assign commit_done_o = snoop_block_o && !drn_found;
   assign wr_addr_o     = addr_q[drn_idx];
   assign wr_data_o     = data_q[drn_idx];
   assign wr_be_o       = be_q[drn_idx];
   assign ovf_o         = ovf_q;

   // Load lookup: at most one slot matches
   always_comb begin
      ld_data_o = '0;
      ld_be_o   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ld_hit[i]) begin
            ld_data_o = ld_data_o | data_q[i];
            ld_be_o   = ld_be_o | be_q[i];
         end
      end
   end
   assign ld_hit_o = |ld_hit;

   always_comb begin
      vld_d   = vld_q;
      sent_d  = sent_q;
      owned_d = owned_q;
      state_d = state_q;
      if (kill) begin
         vld_d   = '0;
         sent_d  = '0;
         owned_d = '0;
         state_d = SWB_IDLE;
      end else if (state_q == SWB_DRAIN) begin
         if (wr_valid_o && wr_ready_i) begin
            vld_d[drn_idx]   = 1'b0;
            sent_d[drn_idx]  = 1'b0;
            owned_d[drn_idx] = 1'b0;
         end
         if (!drn_found) state_d = SWB_IDLE;
      end else begin
         owned_d = owned_q | gnt_take;
         if (own_req_valid_o && own_req_ready_i) sent_d[req_idx] = 1'b1;
         if (state_q == SWB_IDLE) begin
            if (store_alloc) vld_d[free_idx] = 1'b1;
            if (commit_i) state_d = SWB_WAIT;
         end else if (all_owned) begin
            state_d = SWB_DRAIN;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SWB_IDLE;
         vld_q   <= '0;
         sent_q  <= '0;
         owned_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         vld_q   <= vld_d;
         sent_q  <= sent_d;
         owned_q <= owned_d;
         ovf_q   <= store_try && !(|st_hit) && !free_found;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= '0;
            data_q[i] <= '0;
            be_q[i]   <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (store_alloc && (free_idx == IDX_W'(i))) begin
               addr_q[i] <= st_addr_i;
               be_q[i]   <= st_be_i;
               for (int b = 0; b < BE_W; b++)
                  data_q[i][b*8 +: 8] <= st_be_i[b] ? st_data_i[b*8 +: 8] : 8'h00;
            end else if (store_merge && st_hit[i]) begin
               be_q[i] <= be_q[i] | st_be_i;
               for (int b = 0; b < BE_W; b++)
                  if (st_be_i[b]) data_q[i][b*8 +: 8] <= st_data_i[b*8 +: 8];
            end
         end
      end
   end

   // R2
   uniq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(st_hit));
   // R2
   merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_merge |=> ($countones(vld_q) == $past($countones(vld_q))));
   // R4
   wr_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> all_owned);
   // R5
   drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> snoop_block_o);
   // R6
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (vld_q == '0));
   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> ($past(st_valid_i) && $past(vld_q) == {DEPTH{1'b1}}));
   // R10
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SWB_WAIT && !abort_i) |=> (vld_q == $past(vld_q)));
endmodule

// File: tb/spec_wbuf_bench.sv
module spec_wbuf_bench;
   localparam int DEPTH = 4;
   localparam int DW    = 32;
   localparam int AW    = 16;
   localparam int BW    = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st_valid = 0, commit = 0, abort = 0, req_ready = 0, gnt_valid = 0, wr_ready = 0;
   logic [AW-1:0] st_addr = '0, ld_addr = '0, gnt_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic [BW-1:0] st_be = '0;
   logic ld_hit, done, req_valid, cancel, wr_valid, snoop, ovf;
   logic [DW-1:0] ld_data, wr_data;
   logic [BW-1:0] ld_be, wr_be;
   logic [AW-1:0] req_addr, wr_addr;

   always #5 clk = ~clk;

   spec_wbuf #(.DEPTH(DEPTH), .DATA_W(DW), .ADDR_W(AW)) u_spec_wbuf (
      .clk(clk), .rst_n(rst_n),
      .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_be_i(st_be),
      .ld_addr_i(ld_addr), .ld_hit_o(ld_hit), .ld_data_o(ld_data), .ld_be_o(ld_be),
      .commit_i(commit), .abort_i(abort), .commit_done_o(done),
      .own_req_valid_o(req_valid), .own_req_ready_i(req_ready), .own_req_addr_o(req_addr),
      .own_gnt_valid_i(gnt_valid), .own_gnt_addr_i(gnt_addr), .own_cancel_o(cancel),
      .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_be_o(wr_be), .snoop_block_o(snoop), .ovf_o(ovf));

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [BW-1:0] b;
      bit            sent;
      bit            own;
   } ment_t;

   ment_t mq[$];
   int    mst  = 0;   // 0 idle, 1 waiting for grants, 2 draining
   bit    movf = 0;
   int    n_chk = 0, n_bad = 0;

   task automatic expect_eq(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic int find(logic [AW-1:0] a);
      foreach (mq[k]) if (mq[k].a == a) return k;
      return -1;
   endfunction

   function automatic int first_unsent();
      foreach (mq[k]) if (!mq[k].sent) return k;
      return -1;
   endfunction

   // Per-cycle comparison of every output against the behavioural model
   task automatic compare_all();
      int p, h;
      bit outstanding = 0;
      p = first_unsent();
      h = find(ld_addr);
      foreach (mq[k]) if (mq[k].sent && !mq[k].own) outstanding = 1;
      expect_eq("R3", "own_req_valid", req_valid, (mst != 2) && (p >= 0) && !abort);
      if (req_valid && p >= 0) expect_eq("R3", "own_req_addr", req_addr, mq[p].a);
      expect_eq("R6", "own_cancel", cancel, abort && (mst != 2) && outstanding);
      expect_eq("R1", "wr_valid", wr_valid, (mst == 2) && (mq.size() > 0));
      if (wr_valid && mq.size() > 0) begin
         expect_eq("R5", "wr_addr", wr_addr, mq[0].a);
         expect_eq("R5", "wr_data", wr_data, mq[0].d);
         expect_eq("R5", "wr_be", wr_be, mq[0].b);
      end
      expect_eq("R5", "snoop_block", snoop, mst == 2);
      expect_eq("R5", "commit_done", done, (mst == 2) && (mq.size() == 0));
      expect_eq("R7", "ovf", ovf, movf);
      expect_eq("R8", "ld_hit", ld_hit, h >= 0);
      if (h >= 0) begin
         expect_eq("R8", "ld_data", ld_data, mq[h].d);
         expect_eq("R8", "ld_be", ld_be, mq[h].b);
      end
   endtask

   task automatic model_step();
      int p, h;
      bit all_own = 1, store_try, req_fire, novf;
      p = first_unsent();
      foreach (mq[k]) if (!mq[k].own) all_own = 0;
      req_fire  = (mst != 2) && (p >= 0) && !abort && req_ready;
      store_try = st_valid && (mst == 0) && !abort;
      h = find(st_addr);
      novf = store_try && (h < 0) && (mq.size() == DEPTH);
      if (abort && mst != 2) begin
         mq.delete();
         mst = 0;
      end else if (mst == 2) begin
         if (mq.size() > 0) begin
            if (wr_ready) void'(mq.pop_front());
         end else mst = 0;
      end else begin
         if (gnt_valid)
            foreach (mq[k]) if (mq[k].a == gnt_addr && mq[k].sent) mq[k].own = 1;
         if (req_fire) mq[p].sent = 1;
         if (mst == 0) begin
            if (store_try && h >= 0) begin
               mq[h].b = mq[h].b | st_be;
               for (int b = 0; b < BW; b++)
                  if (st_be[b]) mq[h].d[b*8 +: 8] = st_data[b*8 +: 8];
            end else if (store_try && mq.size() < DEPTH) begin
               ment_t e;
               e.a = st_addr; e.b = st_be; e.sent = 0; e.own = 0; e.d = '0;
               for (int b = 0; b < BW; b++)
                  if (st_be[b]) e.d[b*8 +: 8] = st_data[b*8 +: 8];
               mq.push_back(e);
            end
            if (commit) mst = 1;
         end else if (all_own) mst = 2;
      end
      movf = novf;
   endtask

   task automatic tick();
      #1 compare_all();
      @(posedge clk);
      model_step();
      @(negedge clk);
      st_valid = 0; commit = 0; abort = 0; gnt_valid = 0;
   endtask

   task automatic store(logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] b);
      st_valid = 1; st_addr = a; st_data = d; st_be = b;
      tick();
   endtask

   task automatic grant(logic [AW-1:0] a);
      gnt_valid = 1; gnt_addr = a;
      tick();
   endtask

   bit finished = 0;

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R9 reset state
      expect_eq("R9", "outputs", {ld_hit, done, req_valid, cancel, wr_valid, snoop, ovf}, 0);
      @(negedge clk);
      rst_n = 1;

      // R2 R8 merge and forwarding
      store(16'h0010, 32'h11223344, 4'b1111);
      store(16'h0020, 32'hAABBCCDD, 4'b0011);
      store(16'h0010, 32'h55667788, 4'b0100);
      store(16'h0020, 32'hEE000000, 4'b1000);
      ld_addr = 16'h0010;
      #1 expect_eq("R2", "merged data", ld_data, 32'h11663344);
      expect_eq("R8", "hit", ld_hit, 1);
      ld_addr = 16'h0020;
      #1 expect_eq("R2", "merged data", ld_data, 32'hEE00CCDD);
      expect_eq("R2", "merged be", ld_be, 4'b1011);
      ld_addr = 16'h0030;
      #1 expect_eq("R8", "miss", ld_hit, 0);
      tick();

      // R3 requests in first-store order, none for merges
      req_ready = 1;
      #1 expect_eq("R3", "first req", req_addr, 16'h0010);
      tick();
      #1 expect_eq("R3", "second req", req_addr, 16'h0020);
      tick();
      #1 expect_eq("R3", "no more req", req_valid, 0);
      tick();

      // R4 commit stalls until all grants
      wr_ready = 1;
      commit = 1;
      tick();
      repeat (3) tick();
      #1 expect_eq("R4", "stall", wr_valid, 0);
      grant(16'h0020);
      tick(); tick();
      #1 expect_eq("R4", "stall one grant", wr_valid, 0);
      grant(16'h0010);
      tick();
      #1 expect_eq("R5", "drain starts", wr_valid, 1);
      expect_eq("R5", "first write", wr_addr, 16'h0010);
      expect_eq("R5", "snoop", snoop, 1);
      // R5 abort ignored during drain, R10 store ignored
      wr_ready = 0; abort = 1; st_valid = 1; st_addr = 16'h0777; st_be = 4'hF;
      tick();
      #1 expect_eq("R5", "abort ignored", wr_addr, 16'h0010);
      wr_ready = 1;
      tick();
      #1 expect_eq("R5", "second write", wr_data, 32'hEE00CCDD);
      tick();
      #1 expect_eq("R5", "done", done, 1);
      tick();
      #1 expect_eq("R5", "snoop released", snoop, 0);
      ld_addr = 16'h0777;
      #1 expect_eq("R10", "store in drain dropped", ld_hit, 0);

      // R7 overflow
      req_ready = 0;
      for (int i = 0; i < DEPTH; i++) store(16'h0100 + 16'(i), 32'h1000 + 32'(i), 4'hF);
      store(16'h0104, 32'hDEADBEEF, 4'hF);
      #1 expect_eq("R7", "ovf pulse", ovf, 1);
      ld_addr = 16'h0104;
      #1 expect_eq("R7", "rejected", ld_hit, 0);
      store(16'h0101, 32'h0000FF00, 4'b0010);
      #1 expect_eq("R7", "ovf one cycle", ovf, 0);
      ld_addr = 16'h0101;
      #1 expect_eq("R2", "merge when full", ld_data, 32'h0000FF01);

      // R6 abort with outstanding requests
      req_ready = 1;
      tick(); tick();
      req_ready = 0;
      abort = 1;
      #1 expect_eq("R6", "cancel", cancel, 1);
      tick();
      ld_addr = 16'h0100;
      #1 expect_eq("R6", "cleared", ld_hit, 0);
      grant(16'h0100);
      #1 expect_eq("R6", "late grant", ld_hit, 0);

      // R10 store during wait ignored
      req_ready = 1;
      store(16'h0200, 32'h12345678, 4'hF);
      commit = 1;
      tick();
      store(16'h0300, 32'h87654321, 4'hF);
      ld_addr = 16'h0300;
      #1 expect_eq("R10", "wait store dropped", ld_hit, 0);
      grant(16'h0200);
      repeat (6) tick();

      // R5 empty commit finishes at once
      commit = 1;
      tick(); tick();
      #1 expect_eq("R5", "empty done", done, 1);
      expect_eq("R1", "no write", wr_valid, 0);
      repeat (4) tick();

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule